// File: doc/BRIEF.md
# Region-Decoded Load/Store Port

This block sits between the data port of a processor and a set of memory regions, each of which is an ordinary synchronous RAM or ROM. A request carries an address, an access size (byte, halfword or word), a write flag, write data and the region byte of the current program counter. The top eight address bits pick a region. The block masks the offset to that region's size and drives a single select line together with a shared address, byte-enable and write-data bus. One cycle later it returns the read data, aligned to the access size.

The block enforces the access rules of each region. A misaligned load does not fault: it is rotated within the aligned word or halfword. A byte store to video memory is widened to its whole halfword, and is dropped in the upper part of that region. Byte stores to sprite attribute memory are dropped. Stores to the read-only regions are dropped. The boot ROM can be read only while the program counter is inside it; at any other time a read returns the last word it delivered. Reads past the end of the boot ROM, and reads past the configured cartridge size, return zero. Addresses in unmapped regions produce an error pulse.

Top module: `memRegionPort`

## Requirements
- R1: Region byte reqAddr[31:24] decodes as 0x00 boot ROM (memSel bit 0), 0x02 work RAM (bit 1), 0x03 internal RAM (bit 2), 0x04 I/O (bit 3), 0x05 palette (bit 4), 0x06 video (bit 5), 0x07 sprite attributes (bit 6), 0x08 to 0x0D cartridge (bit 7). All other values are unmapped. An access that reaches memory raises exactly one memSel bit in the request cycle. memAddr is the offset masked to the region's size, with bits 1:0 cleared. The offset widths are 14, 18, 15, 10, 10, 17, 10 and 25 bits in that order.
- R2: A read request (reqWrite=0) gives rspValid=1 in the next cycle, with rspData valid in that cycle. A write request never gives rspValid.
- R3: A word read (reqSize 2, or 3, which acts as word) returns the aligned word rotated right by 8*reqAddr[1:0].
- R4: A halfword read (reqSize 1) returns the halfword in lanes selected by reqAddr[1], with its two bytes swapped when reqAddr[0]=1. The result is zero-extended.
- R5: A byte read (reqSize 0) returns byte lane reqAddr[1:0], zero-extended. An I/O byte read enables both lanes of the containing halfword (memBe 4'b0011 or 4'b1100). Other byte reads enable one lane, where memBe bit i stands for data bits 8i+7:8i.
- R6: A word store drives memBe=4'b1111 with the data unchanged. A halfword store enables lanes 1:0 or 3:2 by reqAddr[1], with data {2{wdata[15:0]}}. A byte store enables lane reqAddr[1:0], with data {4{wdata[7:0]}}. memWe is 1 for every store that reaches memory.
- R7: A byte store to video memory enables both lanes of the containing halfword, with the byte replicated. When reqAddr[23:0] >= 0x018000 such a store is dropped, with no select.
- R8: Byte stores to sprite attribute memory, and all stores to the boot ROM or the cartridge, are dropped with no select and no error.
- R9: With pcRegion=0x00, a boot ROM read whose reqAddr[23:0] is 0x4000 or more returns 0 and raises no select.
- R10: A boot ROM read with pcRegion other than 0x00 raises no select. It returns the last raw word delivered by a boot ROM read made while pcRegion was 0x00 (0 after reset), aligned per R3 to R5.
- R11: A cartridge read whose offset reqAddr[24:0] is at or above romBytes returns 0 and raises no select.
- R12: An access to an unmapped region raises no select. It gives rspError=1 for exactly the next cycle, and a read in that case returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 store, 0 load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Store data, right-justified |
| pcRegion | input | 8 | Region byte of the current program counter |
| romBytes | input | 26 | Configured cartridge size in bytes |
| memSel | output | 8 | One select per region |
| memWe | output | 1 | Write strobe for the selected region |
| memAddr | output | 25 | Masked, word-aligned byte offset |
| memBe | output | 4 | Byte-lane enables |
| memWdata | output | 32 | Lane-steered write data |
| memRdata | input | 256 | Read data from each region, region i in bits 32i+31:32i, one cycle after its select |
| rspValid | output | 1 | Read response present |
| rspData | output | 32 | Aligned read data |
| rspError | output | 1 | Unmapped-access pulse |

## Verification
The assertions check the following on every cycle: at most one region is selected; a response or error appears only one cycle after a request; sprite byte stores and protected boot ROM reads never reach memory; and the lane patterns for word stores and for widened video byte stores. Rotation amounts, the zero-returning limits of the boot ROM and cartridge, and the contents of the boot ROM latch depend on the data path. Only the bench's scenarios can show them, by comparing rspData against a data pattern computed per region and offset.

// File: rtl/memPathPkg.sv
package memPathPkg;
  localparam int NREG = 8;

  typedef enum logic [2:0] {
    RG_BOOT = 3'd0, RG_WORK = 3'd1, RG_INTL = 3'd2, RG_IO = 3'd3,
    RG_PAL = 3'd4, RG_VID = 3'd5, RG_SPR = 3'd6, RG_CART = 3'd7
  } regionT;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2
  } sizeT;

  // strobes for the request cycle
  typedef struct packed {
    logic       go;
    logic       wr;
    regionT     region;
    sizeT       size;
    logic [1:0] low;
    logic       halfLanes;
  } issueT;

  // strobes for the response cycle
  typedef struct packed {
    logic       valid;
    logic       bad;
    logic       zero;
    logic       fromLatch;
    logic       loadLatch;
    regionT     region;
    sizeT       size;
    logic [1:0] low;
  } respT;
endpackage

// File: rtl/memPathCtrl.sv
module memPathCtrl
  import memPathPkg::*;
#(
  parameter int          BOOT_AW        = 14,
  parameter int          CART_AW        = 25,
  parameter logic [23:0] VID_BYTE_LIMIT = 24'h018000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [1:0]         reqSize,
  input  logic [31:0]        reqAddr,
  input  logic [7:0]         pcRegion,
  input  logic [CART_AW:0]   romBytes,
  output issueT              issue,
  output respT               resp,
  output logic [NREG-1:0]    memSel,
  output logic               memWe,
  output logic               rspValid,
  output logic               rspError
);
  regionT rg;
  sizeT   sz;
  logic   mapped, isRd, fromLatch, zeroRd, dropWr, go, bootPast, cartPast;
  respT   respNext;

  always_comb begin
    mapped = 1'b1;
    rg     = RG_BOOT;
    case (reqAddr[31:24])
      8'h00: rg = RG_BOOT;
      8'h02: rg = RG_WORK;
      8'h03: rg = RG_INTL;
      8'h04: rg = RG_IO;
      8'h05: rg = RG_PAL;
      8'h06: rg = RG_VID;
      8'h07: rg = RG_SPR;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: rg = RG_CART;
      default: mapped = 1'b0;
    endcase
    sz        = (reqSize == 2'd3) ? SZ_WORD : sizeT'(reqSize);
    bootPast  = |reqAddr[23:BOOT_AW];
    cartPast  = {1'b0, reqAddr[CART_AW-1:0]} >= romBytes;
    isRd      = reqValid && !reqWrite;
    fromLatch = isRd && mapped && rg == RG_BOOT && pcRegion != 8'h00;
    zeroRd    = isRd && mapped &&
                ((rg == RG_BOOT && pcRegion == 8'h00 && bootPast) ||
                 (rg == RG_CART && cartPast));
    dropWr    = reqWrite && (rg == RG_BOOT || rg == RG_CART ||
                (sz == SZ_BYTE && (rg == RG_SPR ||
                 (rg == RG_VID && reqAddr[23:0] >= VID_BYTE_LIMIT))));
    go        = reqValid && mapped && !fromLatch && !zeroRd && !dropWr;

    issue.go        = go;
    issue.wr        = reqWrite;
    issue.region    = rg;
    issue.size      = sz;
    issue.low       = reqAddr[1:0];
    issue.halfLanes = (sz == SZ_BYTE) &&
                      ((rg == RG_IO && !reqWrite) || (rg == RG_VID && reqWrite));

    respNext.valid     = isRd;
    respNext.bad       = reqValid && !mapped;
    respNext.zero      = zeroRd;
    respNext.fromLatch = fromLatch;
    respNext.loadLatch = go && !reqWrite && rg == RG_BOOT;
    respNext.region    = rg;
    respNext.size      = sz;
    respNext.low       = reqAddr[1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : gSel
    assign memSel[g] = go && (rg == regionT'(g));
  end
  assign memWe = go && reqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) resp <= '0;
    else       resp <= respNext;
  end

  assign rspValid = resp.valid;
  assign rspError = resp.bad;

  p_one_sel_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memSel));
  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite));
  p_err_cause_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> $past(reqValid));
  p_spr_byte_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 2'd0 && reqAddr[31:24] == 8'h07) |-> memSel == '0);
  p_prot_boot_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[31:24] == 8'h00 && pcRegion != 8'h00) |-> !memSel[0]);
endmodule

// File: rtl/memPathData.sv
module memPathData
  import memPathPkg::*;
#(
  parameter int BOOT_AW = 14,
  parameter int WORK_AW = 18,
  parameter int INTL_AW = 15,
  parameter int IO_AW   = 10,
  parameter int PAL_AW  = 10,
  parameter int VID_AW  = 17,
  parameter int SPR_AW  = 10,
  parameter int CART_AW = 25
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  issueT                issue,
  input  respT                 resp,
  input  logic [CART_AW-1:0]   reqOff,
  input  logic [31:0]          reqWdata,
  input  logic [NREG*32-1:0]   memRdata,
  output logic [CART_AW-1:0]   memAddr,
  output logic [3:0]           memBe,
  output logic [31:0]          memWdata,
  output logic [31:0]          rspData
);
  localparam logic [CART_AW-1:0] ALIGN_MASK = {{(CART_AW-2){1'b1}}, 2'b00};

  function automatic logic [CART_AW-1:0] sizeMask(input int aw);
    return CART_AW'((64'd1 << aw) - 64'd1);
  endfunction

  logic [CART_AW-1:0] offMask;
  logic [31:0] rdArr [NREG];
  logic [31:0] bootLatch, raw, aligned;
  logic [63:0] dbl;
  logic [15:0] half;

  for (genvar g = 0; g < NREG; g++) begin : gUnpack
    assign rdArr[g] = memRdata[g*32 +: 32];
  end

  always_comb begin
    case (issue.region)
      RG_BOOT: offMask = sizeMask(BOOT_AW);
      RG_WORK: offMask = sizeMask(WORK_AW);
      RG_INTL: offMask = sizeMask(INTL_AW);
      RG_IO:   offMask = sizeMask(IO_AW);
      RG_PAL:  offMask = sizeMask(PAL_AW);
      RG_VID:  offMask = sizeMask(VID_AW);
      RG_SPR:  offMask = sizeMask(SPR_AW);
      default: offMask = sizeMask(CART_AW);
    endcase
    memAddr = reqOff & offMask & ALIGN_MASK;

    case (issue.size)
      SZ_WORD: begin
        memBe    = 4'b1111;
        memWdata = reqWdata;
      end
      SZ_HALF: begin
        memBe    = issue.low[1] ? 4'b1100 : 4'b0011;
        memWdata = {2{reqWdata[15:0]}};
      end
      default: begin
        if (issue.halfLanes) memBe = issue.low[1] ? 4'b1100 : 4'b0011;
        else                 memBe = 4'b0001 << issue.low;
        memWdata = {4{reqWdata[7:0]}};
      end
    endcase
  end

  // response alignment
  always_comb begin
    raw  = resp.fromLatch ? bootLatch : rdArr[resp.region];
    dbl  = {raw, raw};
    half = resp.low[1] ? raw[31:16] : raw[15:0];
    case (resp.size)
      SZ_WORD: aligned = dbl[{resp.low, 3'b000} +: 32];
      SZ_HALF: aligned = {16'h0, resp.low[0] ? {half[7:0], half[15:8]} : half};
      default: aligned = {24'h0, dbl[{resp.low, 3'b000} +: 8]};
    endcase
    rspData = (resp.valid && !resp.zero && !resp.bad) ? aligned : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               bootLatch <= '0;
    else if (resp.loadLatch) bootLatch <= rdArr[RG_BOOT];
  end

  p_word_be_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issue.go && issue.wr && issue.size == SZ_WORD) |-> memBe == 4'b1111);
  p_vid_byte_lanes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issue.go && issue.wr && issue.region == RG_VID && issue.size == SZ_BYTE)
      |-> ((memBe == 4'b0011 || memBe == 4'b1100) && memWdata[7:0] == memWdata[15:8]));
  p_blank_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    (resp.valid && resp.bad) |-> rspData == 32'h0);
endmodule

// File: rtl/memRegionPort.sv
module memRegionPort
  import memPathPkg::*;
#(
  parameter int          BOOT_AW        = 14,
  parameter int          WORK_AW        = 18,
  parameter int          INTL_AW        = 15,
  parameter int          IO_AW          = 10,
  parameter int          PAL_AW         = 10,
  parameter int          VID_AW         = 17,
  parameter int          SPR_AW         = 10,
  parameter int          CART_AW        = 25,
  parameter logic [23:0] VID_BYTE_LIMIT = 24'h018000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic [31:0]          reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic [7:0]           pcRegion,
  input  logic [CART_AW:0]     romBytes,
  output logic [NREG-1:0]      memSel,
  output logic                 memWe,
  output logic [CART_AW-1:0]   memAddr,
  output logic [3:0]           memBe,
  output logic [31:0]          memWdata,
  input  logic [NREG*32-1:0]   memRdata,
  output logic                 rspValid,
  output logic [31:0]          rspData,
  output logic                 rspError
);
  issueT issue;
  respT  resp;

  memPathCtrl #(
    .BOOT_AW(BOOT_AW), .CART_AW(CART_AW), .VID_BYTE_LIMIT(VID_BYTE_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .pcRegion(pcRegion),
    .romBytes(romBytes), .issue(issue), .resp(resp), .memSel(memSel),
    .memWe(memWe), .rspValid(rspValid), .rspError(rspError)
  );

  memPathData #(
    .BOOT_AW(BOOT_AW), .WORK_AW(WORK_AW), .INTL_AW(INTL_AW), .IO_AW(IO_AW),
    .PAL_AW(PAL_AW), .VID_AW(VID_AW), .SPR_AW(SPR_AW), .CART_AW(CART_AW)
  ) i_data (
    .clk(clk), .rstN(rstN), .issue(issue), .resp(resp),
    .reqOff(reqAddr[CART_AW-1:0]), .reqWdata(reqWdata), .memRdata(memRdata),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .rspData(rspData)
  );
endmodule

// File: tb/test_memRegionPort.sv
module test_memRegionPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [7:0]  pcRegion = 8'h00;
  logic [25:0] romBytes = 26'h0100000;
  logic [7:0]  memSel;
  logic        memWe;
  logic [24:0] memAddr;
  logic [3:0]  memBe;
  logic [31:0] memWdata;
  logic [255:0] memRdata;
  logic        rspValid, rspError;
  logic [31:0] rspData;

  int nRun = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] tbLatch = '0;
  logic [31:0] rdReg [8];

  always #10 clk = ~clk;

  memRegionPort i_memRegionPort (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .pcRegion(pcRegion), .romBytes(romBytes), .memSel(memSel), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .rspValid(rspValid), .rspData(rspData), .rspError(rspError)
  );

  function automatic logic [31:0] pattern(input int r, input logic [24:0] a);
    return ({7'h0, a} * 32'h9E3779B1) ^ (32'(r) << 29) ^ 32'h5A5A0000;
  endfunction

  // synchronous memory model: data one cycle after select
  always_ff @(posedge clk) begin
    for (int r = 0; r < 8; r++)
      if (memSel[r] && !memWe) rdReg[r] <= pattern(r, memAddr);
  end
  always_comb begin
    for (int r = 0; r < 8; r++) memRdata[r*32 +: 32] = rdReg[r];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] alignExp(input logic [31:0] w, input int sz, input logic [1:0] lo);
    logic [31:0] r;
    logic [15:0] h;
    if (sz == 0) return 32'(w >> (8 * lo)) & 32'hFF;
    if (sz == 1) begin
      h = lo[1] ? w[31:16] : w[15:0];
      return lo[0] ? {16'h0, h[7:0], h[15:8]} : {16'h0, h};
    end
    r = w;
    for (int i = 0; i < lo; i++) r = {r[7:0], r[31:8]};
    return r;
  endfunction

  // one access: called at a falling edge, returns at the next falling edge
  task automatic access(input bit wr, input int sz, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [7:0] pc);
    int r, aw, esz;
    bit mapped, latchRd, zero, drop, go, vidB;
    logic [24:0] off;
    logic [7:0] expSel;
    logic [3:0] expBe;
    logic [31:0] expWd, raw, expData;
    string dTag;
    reqValid = 1; reqWrite = wr; reqSize = 2'(sz); reqAddr = addr;
    reqWdata = wd; pcRegion = pc;
    esz = (sz == 3) ? 2 : sz;
    mapped = 1; r = 0;
    case (addr[31:24])
      8'h00: r = 0; 8'h02: r = 1; 8'h03: r = 2; 8'h04: r = 3;
      8'h05: r = 4; 8'h06: r = 5; 8'h07: r = 6;
      8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: r = 7;
      default: mapped = 0;
    endcase
    case (r)
      0: aw = 14; 1: aw = 18; 2: aw = 15; 3: aw = 10;
      4: aw = 10; 5: aw = 17; 6: aw = 10; default: aw = 25;
    endcase
    off = addr[24:0] & 25'((64'd1 << aw) - 1) & ~25'd3;
    latchRd = !wr && mapped && r == 0 && pc != 8'h00;
    zero = !wr && mapped && ((r == 0 && pc == 8'h00 && addr[23:0] >= 24'h4000) ||
                             (r == 7 && {1'b0, addr[24:0]} >= romBytes));
    vidB = wr && esz == 0 && r == 5;
    drop = wr && (r == 0 || r == 7 || (esz == 0 && (r == 6 || (r == 5 && addr[23:0] >= 24'h018000))));
    go = mapped && !latchRd && !zero && !drop;
    expSel = go ? (8'd1 << r) : 8'd0;
    #1;
    chk(memSel == expSel, drop ? (vidB ? "R7 video byte store select" : "R8 dropped store select")
                               : (!mapped ? "R12 unmapped select" : "R1 region select"),
        32'(memSel), 32'(expSel));
    if (go) begin
      chk(memAddr == off, "R1 masked offset", 32'(memAddr), 32'(off));
      if (esz == 2) begin expBe = 4'hF; expWd = wd; end
      else if (esz == 1) begin expBe = addr[1] ? 4'hC : 4'h3; expWd = {2{wd[15:0]}}; end
      else begin
        expBe = ((r == 3 && !wr) || vidB) ? (addr[1] ? 4'hC : 4'h3) : (4'h1 << addr[1:0]);
        expWd = {4{wd[7:0]}};
      end
      chk(memBe == expBe, vidB ? "R7 byte lanes" : (wr ? "R6 byte lanes" : "R5 read lanes"),
          32'(memBe), 32'(expBe));
      chk(memWe == wr, "R6 write strobe", 32'(memWe), 32'(wr));
      if (wr) chk(memWdata == expWd, vidB ? "R7 replicated data" : "R6 write data", memWdata, expWd);
    end
    @(negedge clk);
    reqValid = 0;
    chk(rspValid == !wr, "R2 response valid", 32'(rspValid), 32'(!wr));
    chk(rspError == !mapped, "R12 error pulse", 32'(rspError), 32'(!mapped));
    if (!wr) begin
      raw = latchRd ? tbLatch : pattern(r, off);
      expData = (!mapped || zero) ? 32'h0 : alignExp(raw, esz, addr[1:0]);
      if (!mapped) dTag = "R12 unmapped read data";
      else if (zero) dTag = (r == 0) ? "R9 boot past end" : "R11 cart past size";
      else if (latchRd) dTag = "R10 protected boot read";
      else if (esz == 2) dTag = "R3 word read";
      else if (esz == 1) dTag = "R4 halfword read";
      else dTag = "R5 byte read";
      chk(rspData == expData, dTag, rspData, expData);
      if (go && r == 0) tbLatch = pattern(0, off);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [7:0] tops [13] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                              8'h07, 8'h08, 8'h0A, 8'h0D, 8'h0E, 8'h20};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(rspValid == 0 && rspError == 0 && memSel == 0, "R2 reset state",
        {rspValid, rspError, 22'h0, memSel}, 32'h0);
    rstN = 1;
    @(negedge clk);
    // directed corners
    access(0, 2, 32'h0000_0104, 0, 8'h00);          // boot read, fills latch (R10)
    access(0, 2, 32'h0000_0201, 0, 8'h08);          // protected: latch rotated (R10)
    access(0, 1, 32'h0000_0203, 0, 8'h03);          // protected halfword (R10)
    access(0, 0, 32'h0000_4000, 0, 8'h00);          // boot past end (R9)
    access(0, 2, 32'h0300_0003, 0, 8'h00);          // word rotate 24 (R3)
    access(0, 2, 32'h0200_0002, 0, 8'h00);          // word rotate 16 (R3)
    access(0, 1, 32'h0500_0003, 0, 8'h00);          // odd halfword (R4)
    access(0, 0, 32'h0400_0201, 0, 8'h00);          // I/O byte (R5)
    access(0, 0, 32'h0200_0002, 0, 8'h00);          // work RAM byte (R5)
    access(1, 2, 32'h0300_0002, 32'hCAFE_F00D, 8'h00); // misaligned word store (R6)
    access(1, 1, 32'h0200_0002, 32'h1234_ABCD, 8'h00); // halfword store (R6)
    access(1, 0, 32'h0600_0003, 32'h0000_0077, 8'h00); // video byte widened (R7)
    access(1, 0, 32'h0601_8000, 32'h0000_0055, 8'h00); // video byte dropped (R7)
    access(1, 0, 32'h0700_0010, 32'h0000_0011, 8'h00); // sprite byte dropped (R8)
    access(1, 2, 32'h0800_0000, 32'h1, 8'h00);      // cart store dropped (R8)
    access(0, 2, 32'h0810_0000, 0, 8'h00);          // cart at size (R11)
    access(0, 2, 32'h080F_FFFC, 0, 8'h00);          // cart just below size (R11)
    access(0, 1, 32'h0E00_0000, 0, 8'h00);          // unmapped read (R12)
    access(1, 2, 32'h0100_0000, 32'h5, 8'h00);      // unmapped store (R12)
    access(0, 2, 32'h06FF_FFFC, 0, 8'h00);          // video mask 17 bits (R1)
    // constrained random
    for (int i = 0; i < 400; i++) begin
      a = $urandom;
      a[31:24] = tops[$urandom % 13];
      if (a[31:24] == 8'h00 && ($urandom % 4) != 0) a[23:14] = '0;
      access(($urandom % 3) == 0, $urandom % 4, a, $urandom,
             (($urandom % 4) == 0) ? 8'h02 : 8'h00);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule